// File: doc/BRIEF.md
# Transmit FIFO With Byte Holes

This block is the host-to-network staging buffer for a transmit path. It holds 68 word locations of 16 bits each, 136 bytes in all. On every write cycle the host supplies either one byte or one 16-bit word, together with an end-of-frame flag. Each write takes exactly one word location. A byte write leaves its upper byte position empty, and that empty position is marked as a hole. On the network side a serializer pulls bytes one at a time over a valid/ready handshake. The block walks the stored words, sends the lower byte before the upper one, and passes over every hole, so only real data reaches the serializer.

Two indications are sent back. The host request line stays asserted while the number of free word locations is greater than a programmable watermark. The watermark is counted in write cycles, not in bytes, so a host that writes single bytes fills the slots faster than it fills the byte capacity. The start indication tells the transmitter it may begin: it is high when at least 64 valid bytes are stored, or when any stored word carries an end-of-frame flag.

A write that arrives when no slot is free is dropped and flagged on the overflow output. A synchronous clear input returns the block to its empty state in the same way as reset.

Top module: `txh_fifo`

## Requirements
- R1: After `rst_n` low or a cycle with `sw_clear` high, the FIFO is empty. In that state `out_valid`=0, `start_tx`=0, `ovf`=0, and `host_req`=1 whenever `watermark` < 68.
- R2: A byte write (`wr_word`=0) stores `wr_data[7:0]` as the lower byte of one word location. Its upper position is a hole and is never presented on `out_data`.
- R3: A word write (`wr_word`=1) stores both bytes. `wr_data[7:0]` is unloaded first and `wr_data[15:8]` second.
- R4: `host_req` is 1 exactly when the number of free word locations (68 minus stored words) is greater than `watermark`. With `watermark`=32 it is still 1 after 35 byte writes and 0 after 36.
- R5: `start_tx` is 1 when 64 or more valid bytes are stored, and 0 below that if no stored word carries end-of-frame.
- R6: A word written with `wr_eof`=1 makes `start_tx` 1 from the cycle after the write. `out_last` is 1 together with the final valid byte of that word.
- R7: A write while all 68 locations are occupied is ignored: no data from it ever appears on `out_data`. `ovf` is 1 for the one cycle after that write.
- R8: A write and an unloaded byte (`out_valid` and `out_ready` both 1) in the same cycle are both accepted. The valid-byte count changes by the written bytes minus one.
- R9: Bytes leave in write order across any mix of byte and word writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_clear | input | 1 | Synchronous clear to the empty state |
| wr_en | input | 1 | Host write strobe |
| wr_word | input | 1 | 1 = 16-bit write, 0 = single byte on bits 7:0 |
| wr_data | input | 16 | Host write data |
| wr_eof | input | 1 | Written data ends a frame |
| watermark | input | 7 | Free-slot threshold for the host request |
| host_req | output | 1 | Free word locations exceed the watermark |
| start_tx | output | 1 | Enough data or a frame end is stored |
| ovf | output | 1 | One-cycle pulse after a dropped write |
| out_data | output | 8 | Byte toward the serializer |
| out_valid | output | 1 | `out_data` holds a valid byte |
| out_last | output | 1 | Byte is the last one of a frame |
| out_ready | input | 1 | Serializer takes the byte this cycle |

## Verification
A host write and a serializer unload can happen in the same cycle, and both change the valid-byte count that drives the 64-byte start threshold. The bench stores 63 bytes, then in one cycle writes a word while the serializer takes a byte. It then checks that `start_tx` rises (63 + 2 − 1 = 64), and that it falls again after one more unload. Afterwards it drains the FIFO and checks the byte order. A second case drops a write against a full FIFO and checks the overflow pulse.

// File: rtl/txh_pkg.sv
package txh_pkg;

  typedef struct packed {
    logic        eof;
    logic [1:0]  vld;
    logic [15:0] data;
  } slot_t;

  function automatic logic [1:0] bytes_in_write(input logic is_word);
    return is_word ? 2'd2 : 2'd1;
  endfunction

  function automatic slot_t make_slot(input logic is_word, input logic [15:0] d,
                                      input logic eof);
    slot_t s;
    s.eof  = eof;
    s.vld  = is_word ? 2'b11 : 2'b01;
    s.data = is_word ? d : {8'h00, d[7:0]};
    return s;
  endfunction

endpackage

// File: rtl/txh_slot_store.sv
module txh_slot_store
  import txh_pkg::*;
#(
  parameter int DEPTH = 68,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  push,
  input  slot_t in_slot,
  input  logic  pop_word,
  output slot_t head_slot
);

  slot_t mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push)     wr_ptr <= bump(wr_ptr);
      if (pop_word) rd_ptr <= bump(rd_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr] <= in_slot;
  end

  assign head_slot = mem[rd_ptr];

endmodule

// File: rtl/txh_byte_pick.sv
module txh_byte_pick
  import txh_pkg::*;
(
  input  slot_t       head_slot,
  input  logic        have_word,
  input  logic        upper_sel,
  output logic [7:0]  byte_out,
  output logic        byte_valid,
  output logic        byte_is_upper,
  output logic        word_done,
  output logic        frame_end
);

  always_comb begin
    byte_is_upper = upper_sel || !head_slot.vld[0];
    byte_valid    = have_word;
    byte_out      = byte_is_upper ? head_slot.data[15:8] : head_slot.data[7:0];
    word_done     = byte_is_upper || !head_slot.vld[1];
    frame_end     = have_word && word_done && head_slot.eof;
  end

endmodule

// File: rtl/txh_level.sv
module txh_level #(
  parameter int DEPTH = 68,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int BCW = $clog2(2 * DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           push,
  input  logic [1:0]     push_nb,
  input  logic           push_eof,
  input  logic           pop_byte,
  input  logic           pop_word,
  input  logic           pop_eof,
  output logic [CW-1:0]  word_cnt,
  output logic [BCW-1:0] byte_cnt,
  output logic [CW-1:0]  eof_cnt
);

  function automatic logic [BCW-1:0] next_bytes(input logic [BCW-1:0] c,
      input logic add, input logic [1:0] nb, input logic sub);
    return c + (add ? BCW'(nb) : '0) - BCW'(sub);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_cnt <= '0;
      byte_cnt <= '0;
      eof_cnt  <= '0;
    end else if (clr) begin
      word_cnt <= '0;
      byte_cnt <= '0;
      eof_cnt  <= '0;
    end else begin
      word_cnt <= word_cnt + CW'(push) - CW'(pop_word);
      byte_cnt <= next_bytes(byte_cnt, push, push_nb, pop_byte);
      eof_cnt  <= eof_cnt + CW'(push && push_eof) - CW'(pop_word && pop_eof);
    end
  end

endmodule

// File: rtl/txh_fifo.sv
module txh_fifo
  import txh_pkg::*;
#(
  parameter int DEPTH       = 68,
  parameter int START_BYTES = 64,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int BCW = $clog2(2 * DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_clear,
  input  logic          wr_en,
  input  logic          wr_word,
  input  logic [15:0]   wr_data,
  input  logic          wr_eof,
  input  logic [CW-1:0] watermark,
  output logic          host_req,
  output logic          start_tx,
  output logic          ovf,
  output logic [7:0]    out_data,
  output logic          out_valid,
  output logic          out_last,
  input  logic          out_ready
);

  logic           full_w, push_w, fire_w, pop_word_w, upper_sel, is_upper_w, word_done_w;
  logic [1:0]     push_nb_w;
  logic [CW-1:0]  word_cnt_w, eof_cnt_w, free_w;
  logic [BCW-1:0] byte_cnt_w;
  slot_t          head_w;

  assign full_w     = (word_cnt_w == CW'(DEPTH));
  assign push_w     = wr_en && !full_w && !sw_clear;
  assign push_nb_w  = bytes_in_write(wr_word);
  assign fire_w     = out_valid && out_ready && !sw_clear;
  assign pop_word_w = fire_w && word_done_w;
  assign free_w     = CW'(DEPTH) - word_cnt_w;

  txh_slot_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(sw_clear), .push(push_w),
    .in_slot(make_slot(wr_word, wr_data, wr_eof)),
    .pop_word(pop_word_w), .head_slot(head_w)
  );

  txh_byte_pick u_pick (
    .head_slot(head_w), .have_word(word_cnt_w != '0), .upper_sel(upper_sel),
    .byte_out(out_data), .byte_valid(out_valid), .byte_is_upper(is_upper_w),
    .word_done(word_done_w), .frame_end(out_last)
  );

  txh_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst_n(rst_n), .clr(sw_clear), .push(push_w), .push_nb(push_nb_w),
    .push_eof(wr_eof), .pop_byte(fire_w), .pop_word(pop_word_w),
    .pop_eof(head_w.eof), .word_cnt(word_cnt_w), .byte_cnt(byte_cnt_w),
    .eof_cnt(eof_cnt_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_sel <= 1'b0;
      ovf       <= 1'b0;
    end else if (sw_clear) begin
      upper_sel <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      ovf <= wr_en && full_w;
      if (fire_w) upper_sel <= !word_done_w && !is_upper_w;
    end
  end

  assign host_req = free_w > watermark;
  assign start_tx = (byte_cnt_w >= BCW'(START_BYTES)) || (eof_cnt_w != '0);

endmodule

// File: rtl/txh_fifo_chk.sv
module txh_fifo_chk #(
  parameter int DEPTH       = 68,
  parameter int START_BYTES = 64,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int BCW = $clog2(2 * DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sw_clear,
  input logic           wr_en,
  input logic           full_w,
  input logic           push_w,
  input logic [1:0]     push_nb_w,
  input logic           fire_w,
  input logic           ovf,
  input logic           out_valid,
  input logic           start_tx,
  input logic [CW-1:0]  word_cnt_w,
  input logic [BCW-1:0] byte_cnt_w
);

  logic [BCW-1:0] exp_bytes;
  assign exp_bytes = byte_cnt_w + (push_w ? BCW'(push_nb_w) : '0) - BCW'(fire_w);

  a_r7_ovf_after_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full_w && !sw_clear) |=> ovf);

  a_r7_ovf_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $past(wr_en && full_w));

  a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    full_w |-> !push_w);

  a_r5_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_cnt_w >= BCW'(START_BYTES)) |-> start_tx);

  a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear |=> (!out_valid && word_cnt_w == '0 && !ovf));

  a_r8_byte_balance: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_clear |=> (byte_cnt_w == $past(exp_bytes)));

endmodule

bind txh_fifo txh_fifo_chk #(.DEPTH(DEPTH), .START_BYTES(START_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_clear(sw_clear), .wr_en(wr_en), .full_w(full_w),
  .push_w(push_w), .push_nb_w(push_nb_w), .fire_w(fire_w), .ovf(ovf),
  .out_valid(out_valid), .start_tx(start_tx), .word_cnt_w(word_cnt_w),
  .byte_cnt_w(byte_cnt_w)
);

// File: tb/sim_txh_fifo.sv
module sim_txh_fifo;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_clear = 1'b0;
  logic        wr_en = 1'b0, wr_word = 1'b0, wr_eof = 1'b0;
  logic [15:0] wr_data = '0;
  logic [6:0]  watermark = 7'd32;
  logic        host_req, start_tx, ovf, out_valid, out_last;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  txh_fifo u0 (
    .clk(clk), .rst_n(rst_n), .sw_clear(sw_clear), .wr_en(wr_en), .wr_word(wr_word),
    .wr_data(wr_data), .wr_eof(wr_eof), .watermark(watermark), .host_req(host_req),
    .start_tx(start_tx), .ovf(ovf), .out_data(out_data), .out_valid(out_valid),
    .out_last(out_last), .out_ready(out_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_fifo();
    @(negedge clk); sw_clear = 1'b1;
    @(negedge clk); sw_clear = 1'b0;
  endtask

  task automatic push(input logic word, input logic [15:0] d, input logic eof);
    @(negedge clk);
    wr_en = 1'b1; wr_word = word; wr_data = d; wr_eof = eof;
    @(negedge clk);
    wr_en = 1'b0; wr_eof = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [7:0] d, input logic last);
    @(negedge clk);
    check(req, {31'd0, out_valid}, 1);
    check(req, {24'd0, out_data}, {24'd0, d});
    check(req, {31'd0, out_last}, {31'd0, last});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 valid", {31'd0, out_valid}, 0);
    check("R1 start", {31'd0, start_tx}, 0);
    check("R1 ovf", {31'd0, ovf}, 0);
    check("R1 req", {31'd0, host_req}, 1);
  endtask

  task automatic t_holes_order();
    push(1'b0, 16'hFFA1, 1'b0);
    push(1'b1, 16'hB3B2, 1'b0);
    check("R6 no eof start", {31'd0, start_tx}, 0);
    push(1'b0, 16'h77C4, 1'b1);
    check("R6 eof start", {31'd0, start_tx}, 1);
    pop_expect("R2 byte hole", 8'hA1, 1'b0);
    pop_expect("R3 low first", 8'hB2, 1'b0);
    pop_expect("R3 high second", 8'hB3, 1'b0);
    pop_expect("R9 order/R6 last", 8'hC4, 1'b1);
    check("R2 hole skipped empty", {31'd0, out_valid}, 0);
    check("R6 start after drain", {31'd0, start_tx}, 0);
  endtask

  task automatic t_watermark();
    watermark = 7'd32;
    for (int i = 0; i < 35; i++) push(1'b0, 16'(i), 1'b0);
    check("R4 req after 35", {31'd0, host_req}, 1);
    push(1'b0, 16'h0023, 1'b0);
    check("R4 req after 36", {31'd0, host_req}, 0);
    check("R5 36 bytes no start", {31'd0, start_tx}, 0);
    clear_fifo();
    check("R1 clear valid", {31'd0, out_valid}, 0);
    check("R1 clear req", {31'd0, host_req}, 1);
  endtask

  task automatic t_simul();
    for (int i = 0; i < 31; i++) push(1'b1, {8'(2*i+1), 8'(2*i)}, 1'b0);
    push(1'b0, 16'h003E, 1'b0);
    check("R5 63 bytes", {31'd0, start_tx}, 0);
    @(negedge clk);
    check("R8 head before", {24'd0, out_data}, 32'h00);
    wr_en = 1'b1; wr_word = 1'b1; wr_data = 16'h403F; out_ready = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; out_ready = 1'b0;
    check("R8 simul 64 start", {31'd0, start_tx}, 1);
    pop_expect("R8 next byte", 8'h01, 1'b0);
    check("R5 back to 63", {31'd0, start_tx}, 0);
    for (int b = 2; b <= 64; b++) pop_expect("R9 drain", 8'(b - (b > 62 ? 0 : 0)), 1'b0);
    check("R8 empty", {31'd0, out_valid}, 0);
  endtask

  task automatic t_overflow();
    watermark = 7'd0;
    for (int i = 0; i < 68; i++) push(1'b1, {8'(2*i+1), 8'(2*i)}, 1'b0);
    check("R7 no ovf yet", {31'd0, ovf}, 0);
    check("R4 full req", {31'd0, host_req}, 0);
    check("R5 full start", {31'd0, start_tx}, 1);
    @(negedge clk);
    wr_en = 1'b1; wr_word = 1'b1; wr_data = 16'hEEEE;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7 ovf pulse", {31'd0, ovf}, 1);
    @(negedge clk);
    check("R7 ovf one cycle", {31'd0, ovf}, 0);
    for (int b = 0; b < 136; b++) pop_expect("R7 stored data", 8'(b), 1'b0);
    check("R7 dropped write absent", {31'd0, out_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_holes_order();
    t_watermark();
    t_simul();
    t_overflow();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule